// File: doc/BRIEF.md
# Ten-Counter Event Performance Monitor

This block counts hardware events for one processor core. Ten 48-bit counters share one register bus. Counter 0 always counts clock cycles and counter 1 always counts retired instructions. Counters 2 to 9 each take an 8-bit event code that picks one line out of a 256-wide event vector. Two select registers hold those codes, four to a register. Every counter has its own count enable, its own overflow-interrupt enable, and two privilege filters, one for user mode and one for kernel mode. A counter steps only when the core's current privilege matches a filter that is set.

When an increment carries bit 47 of a counter from 0 to 1, the counter's bit in a sticky status register is set. A small interrupt state machine has three states. In OFF, delivery is disabled. In ARMED, fast-interrupt delivery is selected and nothing enabled is pending. In FIRED, the interrupt line is driven. The state machine also sets an active flag, which software clears by rewriting the control register. Software can load any counter directly, and a load always wins over an increment in the same cycle.

Top module: `perf_monitor`

## Requirements
- R1: A counter n in 2..9 steps by exactly one on a clock edge when four things are true: its enable is set, its privilege filter matches, no bus write targets it, and `ev_in[code]` is high, where `code` is its 8-bit select field. Otherwise it holds. No counter ever advances by more than one per edge.
- R2: Counter 0 treats every clock as an event. Counter 1 treats `instr_ret` as its event. Neither counter looks at `ev_in`.
- R3: The control register sits at address 0. Bits [19:12] are the count enables of counters 0..7 and bits [33:32] those of counters 8..9. Bits [27:20] are the interrupt enables of counters 0..7 and bits [45:44] those of counters 8..9. Bits [2:0] are the mode (1 = fast interrupt, any other value = off). Bit 3 reads the active flag. The mode field reads back as 1 or 0.
- R4: Address 2 holds the codes of counters 2..5, with counter n at bits [8(n-2)+7 : 8(n-2)]. Address 3 holds the codes of counters 6..9, with counter n at bits [8(n-6)+7 : 8(n-6)].
- R5: Address 1 holds the filters. The user bits are [7:0] for counters 0..7 and [17:16] for counters 8..9. The kernel bits are [15:8] for counters 0..7 and [19:18] for counters 8..9. `priv_kernel`=1 selects the kernel bit and 0 selects the user bit.
- R6: An increment that takes a counter from 0x7FFF_FFFF_FFFF to 0x8000_0000_0000 sets status bit n on that same edge. A wrap from all ones to zero does not set it, and neither does a bus load.
- R7: The status register sits at address 4, bits [9:0]. A status bit stays set until a 1 is written to it. When a new overflow and a clear land on the same edge, the overflow wins.
- R8: Interrupt state machine. OFF goes to ARMED on a control write with mode 1. ARMED goes to FIRED one edge after an interrupt-enabled status bit is set. FIRED goes back to ARMED when no enabled status bit remains. Any control write moves to ARMED or OFF according to the written mode. `irq` is high only in FIRED.
- R9: The active flag is set on the edge that enters FIRED. It is cleared by any control write, and that clear overrides the set on the same edge.
- R10: Reset clears all counters, enables, interrupt enables, filters, select codes and status, and puts the state machine in OFF with `irq` low.
- R11: Counters are read at addresses 16+n and are zero-extended to 64 bits. A write to 16+n loads bits [47:0] exactly, even when an increment is due on the same edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| instr_ret | input | 1 | One instruction retired this cycle |
| ev_in | input | 256 | Event lines, indexed by event code |
| irq | output | 1 | Fast-interrupt request |

## Verification
On every cycle, the assertions check four behaviours. No counter moves by more than one unless it is loaded, and a load lands exactly. A rise of bit 47 leaves the matching status bit set, and status bits never drop without a clear write. `irq` is only ever high together with fast mode and the active flag, and a control write always clears that flag. The bench scenarios are the only place that shows the rest: the field packing of the select, filter and enable registers, the privilege gating, the fact that counters 0 and 1 ignore the event vector, and the full timing of the interrupt state machine. The bench checks these against a register-level model that follows the requirements.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int NUM_CNT = 10;
    localparam int LO_N    = 8;
    localparam int HI_N    = NUM_CNT - LO_N;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 64;

    localparam logic [ADDR_W-1:0] A_CTRL     = 5'd0;
    localparam logic [ADDR_W-1:0] A_FILT     = 5'd1;
    localparam logic [ADDR_W-1:0] A_SEL_LO   = 5'd2;
    localparam logic [ADDR_W-1:0] A_SEL_HI   = 5'd3;
    localparam logic [ADDR_W-1:0] A_STAT     = 5'd4;
    localparam int                CNT_BASE   = 16;

    // control register field positions
    localparam int CTRL_ACT   = 3;
    localparam int CTRL_EN_LO = 12;
    localparam int CTRL_IE_LO = 20;
    localparam int CTRL_EN_HI = 32;
    localparam int CTRL_IE_HI = 44;

    // filter register field positions
    localparam int FILT_U_LO = 0;
    localparam int FILT_K_LO = 8;
    localparam int FILT_U_HI = 16;
    localparam int FILT_K_HI = 18;

    typedef enum logic [1:0] {
        IRQ_OFF   = 2'd0,
        IRQ_ARMED = 2'd1,
        IRQ_FIRED = 2'd2
    } irq_state_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic             ovf
);
    logic [CNT_W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + 1'b1;
    end

    assign value = q;
    // top bit about to rise because of an increment
    assign ovf = inc && !ld && !q[CNT_W-1] && (&q[CNT_W-2:0]);
endmodule

// File: rtl/pmu_irq_ctrl.sv
module pmu_irq_ctrl
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic mode_fast,
    input  logic pending,
    output logic irq,
    output logic fast,
    output logic active
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = mode_fast ? IRQ_ARMED : IRQ_OFF;
        end else begin
            unique case (state_q)
                IRQ_OFF:   state_d = IRQ_OFF;
                IRQ_ARMED: if (pending)  state_d = IRQ_FIRED;
                IRQ_FIRED: if (!pending) state_d = IRQ_ARMED;
                default:   state_d = IRQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_OFF;
            active  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mode_wr)                     active <= 1'b0;
            else if (state_d == IRQ_FIRED)   active <= 1'b1;
        end
    end

    always_comb begin
        irq  = (state_q == IRQ_FIRED);
        fast = (state_q != IRQ_OFF);
    end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import pmu_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EV_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  priv_kernel,
    input  logic                  instr_ret,
    input  logic [(1<<EV_W)-1:0]  ev_in,
    output logic                  irq
);
    logic [NUM_CNT-1:0]            en_q, ie_q, fu_q, fk_q, status_q;
    logic [NUM_CNT-1:2][EV_W-1:0]  sel_q;
    logic [NUM_CNT-1:0]            inc, ld, ovf;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic                          fast, active, pending;
    logic                          ctrl_wr, stat_wr;
    logic [NUM_CNT-1:0]            stat_clr;
    logic                          unused_wdata;

    assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
    assign stat_wr = reg_we && (reg_addr == A_STAT);
    assign unused_wdata = ^reg_wdata;

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic hit, flt;
        if (n == 0) begin : g_cycles
            assign hit = 1'b1;
        end else if (n == 1) begin : g_instr
            assign hit = instr_ret;
        end else begin : g_event
            assign hit = ev_in[sel_q[n]];
        end
        assign flt    = priv_kernel ? fk_q[n] : fu_q[n];
        assign inc[n] = en_q[n] & flt & hit;
        assign ld[n]  = reg_we && (reg_addr == ADDR_W'(CNT_BASE + n));

        pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld[n]),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .inc    (inc[n]),
            .value  (cnt_val[n]),
            .ovf    (ovf[n])
        );
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            ie_q  <= '0;
            fu_q  <= '0;
            fk_q  <= '0;
            sel_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    en_q <= {reg_wdata[CTRL_EN_HI +: HI_N], reg_wdata[CTRL_EN_LO +: LO_N]};
                    ie_q <= {reg_wdata[CTRL_IE_HI +: HI_N], reg_wdata[CTRL_IE_LO +: LO_N]};
                end
                A_FILT: begin
                    fu_q <= {reg_wdata[FILT_U_HI +: HI_N], reg_wdata[FILT_U_LO +: LO_N]};
                    fk_q <= {reg_wdata[FILT_K_HI +: HI_N], reg_wdata[FILT_K_LO +: LO_N]};
                end
                A_SEL_LO: for (int k = 2; k < 6; k++) sel_q[k] <= reg_wdata[(k-2)*EV_W +: EV_W];
                A_SEL_HI: for (int k = 6; k < 10; k++) sel_q[k] <= reg_wdata[(k-6)*EV_W +: EV_W];
                default: ;
            endcase
        end
    end

    // sticky overflow status, set wins over clear
    assign stat_clr = stat_wr ? reg_wdata[NUM_CNT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~stat_clr) | ovf;
    end

    assign pending = |(status_q & ie_q);

    pmu_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (ctrl_wr),
        .mode_fast (reg_wdata[2:0] == 3'd1),
        .pending   (pending),
        .irq       (irq),
        .fast      (fast),
        .active    (active)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]                  = fast;
                reg_rdata[CTRL_ACT]           = active;
                reg_rdata[CTRL_EN_LO +: LO_N] = en_q[LO_N-1:0];
                reg_rdata[CTRL_IE_LO +: LO_N] = ie_q[LO_N-1:0];
                reg_rdata[CTRL_EN_HI +: HI_N] = en_q[NUM_CNT-1:LO_N];
                reg_rdata[CTRL_IE_HI +: HI_N] = ie_q[NUM_CNT-1:LO_N];
            end
            A_FILT: begin
                reg_rdata[FILT_U_LO +: LO_N] = fu_q[LO_N-1:0];
                reg_rdata[FILT_K_LO +: LO_N] = fk_q[LO_N-1:0];
                reg_rdata[FILT_U_HI +: HI_N] = fu_q[NUM_CNT-1:LO_N];
                reg_rdata[FILT_K_HI +: HI_N] = fk_q[NUM_CNT-1:LO_N];
            end
            A_SEL_LO: for (int k = 2; k < 6; k++) reg_rdata[(k-2)*EV_W +: EV_W] = sel_q[k];
            A_SEL_HI: for (int k = 6; k < 10; k++) reg_rdata[(k-6)*EV_W +: EV_W] = sel_q[k];
            A_STAT:   reg_rdata[NUM_CNT-1:0] = status_q;
            default: begin
                for (int k = 0; k < NUM_CNT; k++) begin
                    if (reg_addr == ADDR_W'(CNT_BASE + k)) reg_rdata[CNT_W-1:0] = cnt_val[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/perf_monitor_chk.sv
module perf_monitor_chk
    import pmu_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_we,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [CNT_W-1:0]              wr_val,
    input logic                          irq,
    input logic                          fast,
    input logic                          active,
    input logic [NUM_CNT-1:0]            status_q,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val
);
    // R8: the line is only driven while fast delivery is selected
    a_r8_irq_needs_fast: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fast);

    // R9: a driven line always goes with the active flag
    a_r9_irq_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> active);

    // R9: control write clears the active flag
    a_r9_ctrl_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CTRL) |=> !active);

    // R7: status bits only fall through a clear write
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == A_STAT) |=> ((status_q & $past(status_q)) == $past(status_q)));

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_c
        // R1: never more than one step per edge
        a_r1_step_le_one: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_addr == ADDR_W'(CNT_BASE + n)) |=>
            (cnt_val[n] == $past(cnt_val[n]) || cnt_val[n] == $past(cnt_val[n]) + 1'b1));

        // R11: a load lands exactly
        a_r11_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(CNT_BASE + n)) |=> (cnt_val[n] == $past(wr_val)));

        // R6: a rise of the top bit by counting leaves the status bit set
        a_r6_rise_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
            (!(reg_we && reg_addr == ADDR_W'(CNT_BASE + n)) && !cnt_val[n][CNT_W-1]) |=>
            (!cnt_val[n][CNT_W-1] || status_q[n]));
    end
endmodule

bind perf_monitor perf_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wr_val   (reg_wdata[CNT_W-1:0]),
    .irq      (irq),
    .fast     (fast),
    .active   (active),
    .status_q (status_q),
    .cnt_val  (cnt_val)
);

// File: tb/test_perf_monitor.sv
`timescale 1ns/1ps
module test_perf_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        priv_kernel = 1'b0;
    logic        instr_ret = 1'b0;
    logic [255:0] ev_in = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    perf_monitor i_perf_monitor (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_kernel(priv_kernel),
        .instr_ret(instr_ret), .ev_in(ev_in), .irq(irq)
    );

    // reference state built from the requirements
    logic [47:0] m_cnt [10];
    logic [7:0]  m_sel [10];
    logic [9:0]  m_en, m_ie, m_fu, m_fk, m_stat;
    int          m_st;
    logic        m_act;

    task automatic model_reset();
        for (int n = 0; n < 10; n++) begin m_cnt[n] = '0; m_sel[n] = '0; end
        m_en = '0; m_ie = '0; m_fu = '0; m_fk = '0; m_stat = '0; m_st = 0; m_act = 1'b0;
    endtask

    task automatic model_step(input logic we, input logic [4:0] a, input logic [63:0] wd);
        logic [9:0] ovf;
        logic pend, hit, flt;
        ovf = '0;
        pend = |(m_stat & m_ie);
        for (int n = 0; n < 10; n++) begin
            if (n == 0)      hit = 1'b1;
            else if (n == 1) hit = instr_ret;
            else             hit = ev_in[m_sel[n]];
            flt = priv_kernel ? m_fk[n] : m_fu[n];
            if (we && a == 5'(16 + n)) m_cnt[n] = wd[47:0];
            else if (m_en[n] && flt && hit) begin
                if (m_cnt[n] == 48'h7FFF_FFFF_FFFF) ovf[n] = 1'b1;
                m_cnt[n] = m_cnt[n] + 48'd1;
            end
        end
        if (we && a == 5'd4) m_stat = m_stat & ~wd[9:0];
        m_stat = m_stat | ovf;
        if (we && a == 5'd0) begin
            m_st  = (wd[2:0] == 3'd1) ? 1 : 0;
            m_act = 1'b0;
            m_en  = {wd[33:32], wd[19:12]};
            m_ie  = {wd[45:44], wd[27:20]};
        end else begin
            case (m_st)
                1: if (pend) begin m_st = 2; m_act = 1'b1; end
                2: if (!pend) m_st = 1;
                default: ;
            endcase
        end
        if (we && a == 5'd1) begin
            m_fu = {wd[17:16], wd[7:0]};
            m_fk = {wd[19:18], wd[15:8]};
        end
        if (we && a == 5'd2) for (int k = 2; k < 6; k++) m_sel[k] = wd[8*(k-2) +: 8];
        if (we && a == 5'd3) for (int k = 6; k < 10; k++) m_sel[k] = wd[8*(k-6) +: 8];
    endtask

    function automatic logic [63:0] exp_reg(input logic [4:0] a);
        logic [63:0] r;
        r = '0;
        case (a)
            5'd0: begin
                r[0] = (m_st != 0); r[3] = m_act;
                r[19:12] = m_en[7:0]; r[27:20] = m_ie[7:0];
                r[33:32] = m_en[9:8]; r[45:44] = m_ie[9:8];
            end
            5'd1: begin
                r[7:0] = m_fu[7:0]; r[15:8] = m_fk[7:0];
                r[17:16] = m_fu[9:8]; r[19:18] = m_fk[9:8];
            end
            5'd2: for (int k = 2; k < 6; k++) r[8*(k-2) +: 8] = m_sel[k];
            5'd3: for (int k = 6; k < 10; k++) r[8*(k-6) +: 8] = m_sel[k];
            5'd4: r[9:0] = m_stat;
            default: if (a >= 5'd16 && a <= 5'd25) r[47:0] = m_cnt[a - 5'd16];
        endcase
        return r;
    endfunction

    function automatic logic [63:0] ctrl_word(input logic fast, input logic [9:0] en, input logic [9:0] ie);
        logic [63:0] w;
        w = '0;
        w[2:0] = fast ? 3'd1 : 3'd0;
        w[19:12] = en[7:0]; w[33:32] = en[9:8];
        w[27:20] = ie[7:0]; w[45:44] = ie[9:8];
        return w;
    endfunction

    function automatic logic [63:0] filt_word(input logic [9:0] fu, input logic [9:0] fk);
        logic [63:0] w;
        w = '0;
        w[7:0] = fu[7:0]; w[17:16] = fu[9:8];
        w[15:8] = fk[7:0]; w[19:18] = fk[9:8];
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    // one clock: drive at falling edge, model the edge, settle after rising edge
    task automatic cycle(input logic we, input logic [4:0] a, input logic [63:0] wd);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        model_step(we, a, wd);
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] wd);
        cycle(1'b1, a, wd);
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a);
        cycle(1'b0, a, 64'd0);
        check(req, reg_rdata, exp_reg(a));
    endtask

    task automatic irq_chk(input string req);
        check(req, {63'd0, irq}, {63'd0, (m_st == 2)});
    endtask

    task automatic check_all(input string req);
        rd_chk(req, 5'd0); rd_chk(req, 5'd1); rd_chk(req, 5'd2);
        rd_chk(req, 5'd3); rd_chk(req, 5'd4); rd_chk(req, 5'd7);
        for (int n = 0; n < 10; n++) rd_chk(req, 5'(16 + n));
        irq_chk(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 5'd0, 64'd0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check_all("R10 reset");

        // R2 R5: cycle counter gated by user filter only
        wr(5'd1, filt_word(10'b0000000001, 10'b0));
        wr(5'd0, ctrl_word(1'b0, 10'b0000000001, 10'b0));
        priv_kernel = 1'b0; idle(5);
        rd_chk("R2 R5 user cycles", 5'd16);
        priv_kernel = 1'b1; idle(5);
        rd_chk("R5 kernel blocked", 5'd16);
        check("R5 exact count", reg_rdata, 64'd6);

        // R2: instruction counter ignores the event lines
        wr(5'd1, filt_word(10'b0000000011, 10'b0000000011));
        wr(5'd0, ctrl_word(1'b0, 10'b0000000010, 10'b0));
        ev_in = '1; instr_ret = 1'b0; idle(4);
        rd_chk("R2 instr idle", 5'd17);
        check("R2 no event leak", reg_rdata, 64'd0);
        instr_ret = 1'b1; idle(3); instr_ret = 1'b0;
        rd_chk("R2 instr count", 5'd17);

        // R4 R1: select packing across both registers
        ev_in = '0;
        wr(5'd2, 64'h33_00_00_00);
        wr(5'd3, 64'h00_00_00_5A);
        wr(5'd1, filt_word(10'h3FF, 10'h3FF));
        wr(5'd0, ctrl_word(1'b0, 10'b0001100100, 10'b0));
        ev_in[8'h33] = 1'b1; idle(4);
        ev_in = '0; ev_in[8'h5A] = 1'b1; idle(2);
        ev_in = '0; ev_in[0] = 1'b1; idle(3);
        ev_in = '0;
        rd_chk("R4 sel lo", 5'd2); rd_chk("R4 sel hi", 5'd3);
        rd_chk("R4 R1 cnt5", 5'd21); rd_chk("R4 R1 cnt6", 5'd22); rd_chk("R1 cnt2", 5'd18);

        // R3: upper enable group for counters 8 and 9
        wr(5'd3, 64'h44_11_00_00);
        wr(5'd0, ctrl_word(1'b0, 10'b1100000000, 10'b0));
        ev_in[8'h11] = 1'b1; ev_in[8'h44] = 1'b1; idle(5); ev_in = '0;
        rd_chk("R3 ctrl", 5'd0); rd_chk("R3 cnt8", 5'd24); rd_chk("R3 cnt9", 5'd25);

        // R6 R8 R9: overflow at top bit, interrupt delivery
        wr(5'd2, 64'h00_00_10_00);
        wr(5'd19, 64'h7FFF_FFFF_FFFE);
        wr(5'd20, 64'hFFFF_FFFF_FFFF);
        wr(5'd0, ctrl_word(1'b1, 10'b0000011000, 10'b0000001000));
        rd_chk("R8 armed", 5'd0); irq_chk("R8 armed no irq");
        ev_in[8'h10] = 1'b1; ev_in[8'h00] = 1'b1;
        cycle(1'b0, 5'd4, 64'd0); irq_chk("R8 below top");
        cycle(1'b0, 5'd4, 64'd0);
        check("R6 status set", reg_rdata, exp_reg(5'd4)); irq_chk("R8 one edge later");
        ev_in = '0;
        cycle(1'b0, 5'd0, 64'd0); irq_chk("R8 fired");
        check("R9 active set", reg_rdata, exp_reg(5'd0));
        rd_chk("R6 wrap no status", 5'd20);
        rd_chk("R6 status", 5'd4);

        // R7: write one to clear, irq drops back to armed
        wr(5'd4, 64'h0);
        rd_chk("R7 zero write keeps", 5'd4);
        wr(5'd4, 64'h8);
        rd_chk("R7 cleared", 5'd4);
        idle(1); irq_chk("R8 back to armed");
        rd_chk("R9 active sticky", 5'd0);
        wr(5'd0, ctrl_word(1'b1, 10'b0000011000, 10'b0000001000));
        rd_chk("R9 ctrl clears active", 5'd0);

        // R11: load wins over increment
        wr(5'd0, ctrl_word(1'b0, 10'b0000000100, 10'b0));
        ev_in[0] = 1'b1;
        wr(5'd18, 64'hABCD_0123_4567_89AB);
        rd_chk("R11 load exact", 5'd18);
        ev_in = '0;
        rd_chk("R11 unmapped", 5'd9);

        // constrained random rounds
        for (int round = 0; round < 4; round++) begin
            wr(5'd2, {$urandom, $urandom});
            wr(5'd3, {$urandom, $urandom});
            wr(5'd1, {$urandom, $urandom});
            for (int n = 2; n < 10; n++)
                if ($urandom_range(0, 2) == 0) wr(5'(16 + n), {16'h0, 16'h7FFF, 32'hFFFF_FFF0 | 32'($urandom_range(0, 15))});
            wr(5'd0, ctrl_word(1'($urandom_range(0, 1)), 10'($urandom), 10'($urandom)));
            for (int i = 0; i < 300; i++) begin
                logic [4:0] a;
                ev_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
                priv_kernel = 1'($urandom);
                instr_ret = 1'($urandom);
                case ($urandom_range(0, 9))
                    0: wr(5'd4, {54'd0, 10'($urandom)});
                    1: wr(5'd0, ctrl_word(1'($urandom_range(0, 1)), 10'($urandom), 10'($urandom)));
                    default: begin
                        a = 5'($urandom_range(0, 25));
                        rd_chk("R1 R6 R7 random", a);
                        irq_chk("R8 R9 random");
                    end
                endcase
            end
            ev_in = '0;
            check_all("R1 R3 R5 random end");
        end
        summary();
    end
endmodule